// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This unit commits the architectural state change that happens when a hart takes an exception or an interrupt. On the cycle its trap strobe is high, it looks at the cause, the current privilege and the two delegation masks. It then decides whether the supervisor level or the machine level handles the trap. In the same edge it loads the new program counter, the new privilege, the cause, exception-PC and trap-value registers of the chosen level, and the updated status word.

The surrounding core feeds in its current PC, privilege, status word, both trap vectors and both delegation masks. It reads the unit's registered outputs as the state after the trap. When the strobe is low, every output holds its value. Trap return, vectored dispatch and software access to the registers belong to neighbouring logic.

Top module: `trap_entry_unit`

## Requirements
- R1: While reset is asserted and after its release, every output is zero except the privilege, which reads machine level (encoding U=0, S=1, M=3).
- R2: For an interrupt (`irq_i`=1), the recorded cause is the code with bit XLEN-1 set, for example 0x80000005 for code 5.
- R3: An exception with code 8 is recorded as 8 when taken from U, 9 when taken from S and 11 when taken from M. The rewritten value is also the one used as the delegation index.
- R4: Exceptions index `edeleg_i` and interrupts index `ideleg_i` by the cause with the interrupt bit removed. The trap goes to S only if the current privilege is U or S and the indexed bit is 1. Otherwise it goes to M.
- R5: On an S-level entry, the PC becomes `stvec_i`, `scause_o` takes the cause, `sepc_o` takes `pc_i` and the privilege becomes S. `mcause_o`, `mepc_o` and `mtval_o` keep their values.
- R6: On an S-level entry, the status word is `status_i` with bit 5 set to old bit 1, bit 8 set to old privilege bit 0, and bit 1 cleared. Every other bit is unchanged.
- R7: On an M-level entry, the PC becomes `mtvec_i`, `mcause_o` takes the cause, `mepc_o` takes `pc_i` and the privilege becomes M. `scause_o`, `sepc_o` and `stval_o` keep their values.
- R8: On an M-level entry, the status word is `status_i` with bit 7 set to old bit 3, bits 12:11 set to the old privilege, and bit 3 cleared. Every other bit is unchanged.
- R9: The trap-value register of the chosen level takes `addr_i` only for exception codes 0, 1, 4, 5, 6, 7, 12, 13 and 15. For every other exception code and for every interrupt, it is written with zero.
- R10: All updates appear after the single clock edge at which `trap_i` is high. With `trap_i` low, no output changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_i | input | 1 | Take a trap on this cycle |
| irq_i | input | 1 | The trap is an interrupt |
| code_i | input | CODE_W | Exception or interrupt number |
| addr_i | input | XLEN | Faulting address |
| pc_i | input | XLEN | PC of the trapping instruction |
| priv_i | input | 2 | Current privilege |
| edeleg_i | input | XLEN | Exception delegation mask |
| ideleg_i | input | XLEN | Interrupt delegation mask |
| stvec_i | input | XLEN | Supervisor trap vector |
| mtvec_i | input | XLEN | Machine trap vector |
| status_i | input | XLEN | Current status word |
| pc_o | output | XLEN | PC after trap entry |
| priv_o | output | 2 | Privilege after trap entry |
| status_o | output | XLEN | Status word after trap entry |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor exception PC |
| stval_o | output | XLEN | Supervisor trap value |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine exception PC |
| mtval_o | output | XLEN | Machine trap value |

## Verification
The hardest cases to reach are the crossed routings. One is an interrupt whose exception-mask bit is set but whose interrupt-mask bit is clear, or the reverse. The other is an environment call whose raw code 8 is delegated while its rewritten code is not. The stimulus sets the two masks to complementary patterns and drives the same code number once as an exception and once as an interrupt. This exposes any mix-up of the two masks or of the index. Back-to-back traps to opposite levels then confirm that the registers of the other level stay put.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_RSVD  = 2'd2,
    LVL_MACH  = 2'd3
  } lvl_e;

  // status word bit positions decoded by neighbouring logic
  localparam int unsigned ST_SIE  = 1;
  localparam int unsigned ST_MIE  = 3;
  localparam int unsigned ST_SPIE = 5;
  localparam int unsigned ST_MPIE = 7;
  localparam int unsigned ST_SPP  = 8;
  localparam int unsigned ST_MPP  = 11;

  localparam int unsigned CODE_ENV_CALL = 8;

  // exception codes that carry a faulting address
  localparam logic [15:0] ADDR_CODE_MASK = 16'b1011_0000_1111_0011;

endpackage

// File: rtl/trap_cause_norm.sv
module trap_cause_norm
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = $clog2(XLEN)
) (
  input  logic              irq_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        priv_i,
  output logic [XLEN-1:0]   cause_o,
  output logic [CODE_W-1:0] index_o
);

  logic              is_env_call;
  logic [CODE_W-1:0] code_fixed;

  always_comb begin
    is_env_call = !irq_i && (code_i == CODE_W'(CODE_ENV_CALL));
    if (is_env_call) begin
      code_fixed = CODE_W'(CODE_ENV_CALL) + CODE_W'(priv_i);
    end else begin
      code_fixed = code_i;
    end
    index_o = code_fixed;
    cause_o = {irq_i, {(XLEN-1-CODE_W){1'b0}}, code_fixed};
  end

endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = $clog2(XLEN)
) (
  input  logic              irq_i,
  input  logic [CODE_W-1:0] index_i,
  input  logic [1:0]        priv_i,
  input  logic [XLEN-1:0]   edeleg_i,
  input  logic [XLEN-1:0]   ideleg_i,
  output logic              to_super_o
);

  logic [XLEN-1:0] mask_sel;
  logic            bit_set;
  logic            low_enough;

  always_comb begin
    mask_sel   = irq_i ? ideleg_i : edeleg_i;
    bit_set    = mask_sel[index_i];
    low_enough = (priv_i == LVL_USER) || (priv_i == LVL_SUPER);
    to_super_o = low_enough && bit_set;
  end

endmodule

// File: rtl/trap_tval_sel.sv
module trap_tval_sel
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = $clog2(XLEN)
) (
  input  logic              irq_i,
  input  logic [CODE_W-1:0] index_i,
  input  logic [XLEN-1:0]   addr_i,
  output logic [XLEN-1:0]   tval_o
);

  logic keep_addr;

  always_comb begin
    keep_addr = 1'b0;
    if (!irq_i && (index_i < CODE_W'(16))) begin
      keep_addr = ADDR_CODE_MASK[index_i[3:0]];
    end
    tval_o = keep_addr ? addr_i : '0;
  end

endmodule

// File: rtl/trap_status_next.sv
module trap_status_next
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] status_i,
  input  logic [1:0]      priv_i,
  input  logic            to_super_i,
  output logic [XLEN-1:0] status_o
);

  always_comb begin
    status_o = status_i;
    if (to_super_i) begin
      status_o[ST_SPIE] = status_i[ST_SIE];
      status_o[ST_SPP]  = priv_i[0];
      status_o[ST_SIE]  = 1'b0;
    end else begin
      status_o[ST_MPIE]           = status_i[ST_MIE];
      status_o[ST_MPP+1:ST_MPP]   = priv_i;
      status_o[ST_MIE]            = 1'b0;
    end
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = $clog2(XLEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_i,
  input  logic              irq_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   addr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [1:0]        priv_i,
  input  logic [XLEN-1:0]   edeleg_i,
  input  logic [XLEN-1:0]   ideleg_i,
  input  logic [XLEN-1:0]   stvec_i,
  input  logic [XLEN-1:0]   mtvec_i,
  input  logic [XLEN-1:0]   status_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [1:0]        priv_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   scause_o,
  output logic [XLEN-1:0]   sepc_o,
  output logic [XLEN-1:0]   stval_o,
  output logic [XLEN-1:0]   mcause_o,
  output logic [XLEN-1:0]   mepc_o,
  output logic [XLEN-1:0]   mtval_o
);

  logic [XLEN-1:0]   cause_w;
  logic [CODE_W-1:0] index_w;
  logic              to_super_w;
  logic [XLEN-1:0]   tval_w;
  logic [XLEN-1:0]   status_w;

  logic              en_common;
  logic              en_super;
  logic              en_mach;
  logic [XLEN-1:0]   pc_nxt;
  logic [1:0]        priv_nxt;

  trap_cause_norm #(.XLEN(XLEN), .CODE_W(CODE_W)) u_cause (
    .irq_i   (irq_i),
    .code_i  (code_i),
    .priv_i  (priv_i),
    .cause_o (cause_w),
    .index_o (index_w)
  );

  trap_route #(.XLEN(XLEN), .CODE_W(CODE_W)) u_route (
    .irq_i      (irq_i),
    .index_i    (index_w),
    .priv_i     (priv_i),
    .edeleg_i   (edeleg_i),
    .ideleg_i   (ideleg_i),
    .to_super_o (to_super_w)
  );

  trap_tval_sel #(.XLEN(XLEN), .CODE_W(CODE_W)) u_tval (
    .irq_i   (irq_i),
    .index_i (index_w),
    .addr_i  (addr_i),
    .tval_o  (tval_w)
  );

  trap_status_next #(.XLEN(XLEN)) u_status (
    .status_i   (status_i),
    .priv_i     (priv_i),
    .to_super_i (to_super_w),
    .status_o   (status_w)
  );

  // next-state and enables
  always_comb begin
    en_common = trap_i;
    en_super  = trap_i && to_super_w;
    en_mach   = trap_i && !to_super_w;
    pc_nxt    = to_super_w ? stvec_i : mtvec_i;
    priv_nxt  = to_super_w ? LVL_SUPER : LVL_MACH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o     <= '0;
      priv_o   <= LVL_MACH;
      status_o <= '0;
    end else if (en_common) begin
      pc_o     <= pc_nxt;
      priv_o   <= priv_nxt;
      status_o <= status_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scause_o <= '0;
      sepc_o   <= '0;
      stval_o  <= '0;
    end else if (en_super) begin
      scause_o <= cause_w;
      sepc_o   <= pc_i;
      stval_o  <= tval_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcause_o <= '0;
      mepc_o   <= '0;
      mtval_o  <= '0;
    end else if (en_mach) begin
      mcause_o <= cause_w;
      mepc_o   <= pc_i;
      mtval_o  <= tval_w;
    end
  end

  // R4: a trap from machine level always lands in machine level
  a_r4_mach_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && priv_i == 2'd3) |=> (priv_o == 2'd3));

  // R5 / R7: the level not chosen keeps its registers
  a_r5_mach_regs_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && priv_o != 2'd0) |=> (priv_o == 2'd1) ->
      ($stable(mcause_o) && $stable(mepc_o) && $stable(mtval_o)));

  a_r7_super_regs_kept: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> (priv_o == 2'd3) ->
      ($stable(scause_o) && $stable(sepc_o) && $stable(stval_o)));

  // R6 / R8: the interrupt enable of the entered level is clear
  a_r6_enable_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> ((priv_o == 2'd1) ? !status_o[1] : !status_o[3]));

  // R9: interrupts never record a trap value
  a_r9_irq_no_tval: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && irq_i) |=> ((priv_o == 2'd1) ? (stval_o == '0) : (mtval_o == '0)));

  // R2: interrupt causes carry the top bit
  a_r2_irq_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && irq_i) |=> ((priv_o == 2'd1) ? scause_o[XLEN-1] : mcause_o[XLEN-1]));

  // R10: nothing moves without a trap strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_i |=> ($stable(pc_o) && $stable(priv_o) && $stable(status_o) &&
                 $stable(scause_o) && $stable(mcause_o) &&
                 $stable(sepc_o) && $stable(mepc_o)));

endmodule

// File: tb/test_trap_entry_unit.sv
`timescale 1ns/1ps
module test_trap_entry_unit;

  typedef struct {
    logic [31:0] pc;
    logic [1:0]  priv;
    logic [31:0] status;
    logic [31:0] scause, sepc, stval, mcause, mepc, mtval;
  } snap_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_i = 1'b0;
  logic        irq_i = 1'b0;
  logic [4:0]  code_i = '0;
  logic [31:0] addr_i = '0, pc_i = '0, edeleg_i = '0, ideleg_i = '0;
  logic [31:0] stvec_i = '0, mtvec_i = '0, status_i = '0;
  logic [1:0]  priv_i = '0;
  logic [31:0] pc_o, status_o, scause_o, sepc_o, stval_o, mcause_o, mepc_o, mtval_o;
  logic [1:0]  priv_o;

  int checks = 0;
  int failures = 0;
  snap_t cur;
  snap_t exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  trap_entry_unit i_trap_entry_unit (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .irq_i(irq_i), .code_i(code_i),
    .addr_i(addr_i), .pc_i(pc_i), .priv_i(priv_i), .edeleg_i(edeleg_i),
    .ideleg_i(ideleg_i), .stvec_i(stvec_i), .mtvec_i(mtvec_i), .status_i(status_i),
    .pc_o(pc_o), .priv_o(priv_o), .status_o(status_o), .scause_o(scause_o),
    .sepc_o(sepc_o), .stval_o(stval_o), .mcause_o(mcause_o), .mepc_o(mepc_o),
    .mtval_o(mtval_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic snap_t model(snap_t s, logic trap, logic irq, logic [4:0] code,
                                  logic [1:0] priv, logic [31:0] ed, logic [31:0] id,
                                  logic [31:0] stv, logic [31:0] mtv, logic [31:0] st,
                                  logic [31:0] addr, logic [31:0] pc);
    snap_t n = s;
    logic [31:0] cause;
    logic        deleg, has_addr;
    if (!trap) return n;
    if (irq) cause = 32'h8000_0000 | 32'(code);
    else if (code == 5'd8) cause = 32'd8 + 32'(priv);
    else cause = 32'(code);
    deleg = irq ? id[cause[4:0]] : ed[cause[4:0]];
    has_addr = !irq && (cause inside {0, 1, 4, 5, 6, 7, 12, 13, 15});
    if (priv <= 2'd1 && deleg) begin
      n.pc = stv; n.priv = 2'd1; n.scause = cause; n.sepc = pc;
      n.stval = has_addr ? addr : 32'd0;
      n.status = st; n.status[5] = st[1]; n.status[8] = priv[0]; n.status[1] = 1'b0;
    end else begin
      n.pc = mtv; n.priv = 2'd3; n.mcause = cause; n.mepc = pc;
      n.mtval = has_addr ? addr : 32'd0;
      n.status = st; n.status[7] = st[3]; n.status[12:11] = priv; n.status[3] = 1'b0;
    end
    return n;
  endfunction

  // driver: one cycle of stimulus, expected state pushed to the scoreboard
  task automatic step(input string tag, input logic trap, input logic irq,
                      input logic [4:0] code, input logic [1:0] priv,
                      input logic [31:0] ed, input logic [31:0] id,
                      input logic [31:0] st, input logic [31:0] addr,
                      input logic [31:0] pc);
    @(negedge clk);
    trap_i = trap; irq_i = irq; code_i = code; priv_i = priv;
    edeleg_i = ed; ideleg_i = id; status_i = st; addr_i = addr; pc_i = pc;
    stvec_i = 32'h0000_1000 + {pc[15:0], 4'h0};
    mtvec_i = 32'h8000_0100 + {pc[15:0], 4'h0};
    cur = model(cur, trap, irq, code, priv, ed, id, stvec_i, mtvec_i, st, addr, pc);
    exp_q.push_back(cur);
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        snap_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "pc", pc_o, e.pc);
        check(t, "priv", {30'd0, priv_o}, {30'd0, e.priv});
        check(t, "status", status_o, e.status);
        check(t, "scause", scause_o, e.scause);
        check(t, "sepc", sepc_o, e.sepc);
        check(t, "stval", stval_o, e.stval);
        check(t, "mcause", mcause_o, e.mcause);
        check(t, "mepc", mepc_o, e.mepc);
        check(t, "mtval", mtval_o, e.mtval);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cur = '{pc: 0, priv: 2'd3, status: 0, scause: 0, sepc: 0, stval: 0,
            mcause: 0, mepc: 0, mtval: 0};
    repeat (3) @(negedge clk);
    // R1: reset values while reset held
    check("R1", "priv in reset", {30'd0, priv_o}, 32'd3);
    check("R1", "pc in reset", pc_o, 32'd0);
    check("R1", "mcause in reset", mcause_o, 32'd0);
    rst_n = 1'b1;
    // R1 after release, idle cycle also covers R10
    step("R1_R10 idle", 1'b0, 1'b0, 5'd0, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1234, 32'h40);

    // R3 env call from U delegated -> S, cause 8, no tval (R9), status (R6)
    step("R3_R5_R6_R9 ecall U", 1'b1, 1'b0, 5'd8, 2'd0, 32'h0000_0100, 32'h0, 32'hA5A5_0A0A, 32'hDEAD_0001, 32'h100);
    // R3 env call from S, raw 8 delegated but 9 not -> M, cause 9 (R8)
    step("R3_R4_R7_R8 ecall S", 1'b1, 1'b0, 5'd8, 2'd1, 32'h0000_0100, 32'h0, 32'h0000_002A, 32'hDEAD_0002, 32'h104);
    // R3 env call from M with full mask -> M, cause 11
    step("R3_R4_R7 ecall M", 1'b1, 1'b0, 5'd8, 2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_1808, 32'hDEAD_0003, 32'h108);
    // R9 load page fault from S delegated -> S, tval = addr
    step("R4_R5_R9 load pf", 1'b1, 1'b0, 5'd13, 2'd1, 32'h0000_2000, 32'h0, 32'h0000_0002, 32'hCAFE_1000, 32'h10C);
    // R9 illegal instruction: tval forced to zero
    step("R7_R9 illegal", 1'b1, 1'b0, 5'd2, 2'd0, 32'h0, 32'h0, 32'h0000_0008, 32'hCAFE_2000, 32'h110);
    // R2 interrupt 5 via interrupt mask only -> S
    step("R2_R4_R9 irq5", 1'b1, 1'b1, 5'd5, 2'd1, 32'h0000_0000, 32'h0000_0020, 32'h0000_0002, 32'hCAFE_3000, 32'h114);
    // R4 interrupt 7: exception mask set, interrupt mask clear -> M
    step("R2_R4_R8 irq7", 1'b1, 1'b1, 5'd7, 2'd0, 32'h0000_0080, 32'h0000_0000, 32'h0000_000A, 32'hCAFE_4000, 32'h118);
    // R9 store access fault from U delegated -> S with tval
    step("R5_R9 store af", 1'b1, 1'b0, 5'd7, 2'd0, 32'h0000_0080, 32'h0, 32'hFFFF_FFFF, 32'hBEEF_0007, 32'h11C);
    // R10 inputs move, strobe low
    step("R10 hold", 1'b0, 1'b1, 5'd3, 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h5555_5555, 32'h999);
    // R9 misaligned fetch code 0 from M -> M, tval = addr
    step("R7_R9 fetch misalign", 1'b1, 1'b0, 5'd0, 2'd3, 32'hFFFF_FFFF, 32'h0, 32'h0000_0008, 32'h0000_0003, 32'h120);
    // R9 store page fault 15 delegated, then code 14 gives zero
    step("R9 store pf", 1'b1, 1'b0, 5'd15, 2'd0, 32'h0000_C000, 32'h0, 32'h0, 32'h7777_0000, 32'h124);
    step("R9 code14", 1'b1, 1'b0, 5'd14, 2'd0, 32'h0000_C000, 32'h0, 32'h0, 32'h7777_1111, 32'h128);
    // R4 code 31 at top of the mask, R2 with wide code
    step("R2_R4 irq31", 1'b1, 1'b1, 5'd31, 2'd0, 32'h0, 32'h8000_0000, 32'h0, 32'h1, 32'h12C);

    @(negedge clk);
    trap_i = 1'b0;
    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule